// File: doc/BRIEF.md
# Sector read-modify-write flash writer

This block takes a write request (start byte address, byte count, and a stream of write bytes) and stores it into a NOR-style flash. In that flash, programming can only turn bits from 1 to 0. The request is cut into passes at sector boundaries. Each pass copies the whole target sector into an on-chip staging buffer. If any byte in the target window is not already erased, the sector is erased. The new bytes are then merged into the buffer, and the full buffer is written back one page at a time. Bytes of the sector outside the window keep their old values.

The flash side is a simple command port with three operations: read one byte, erase one sector, and program one page. Every command is a single-cycle request, and the flash ends it with a done pulse. A program command is followed by one page of bytes, one byte per cycle. The host side uses valid/ready for the request and for each data byte, and receives a one-cycle done pulse when the whole request is finished.

Top module: `flash_rmw_writer`

## Requirements
- R1: After reset the block is idle: `req_ready_o` is 1, and `done_o`, `wd_ready_o`, `fl_req_o` and `fl_wvalid_o` are 0.
- R2: A request is split into passes. Each pass covers the current address up to the smaller of the remaining count and the end of its sector (sector = address / SECTOR_BYTES, offset = address % SECTOR_BYTES). The next pass starts at offset 0 of the following sector.
- R3: Each pass begins with exactly SECTOR_BYTES read-byte commands (`fl_op_o` = 0) covering the whole target sector. Every command is a one-cycle `fl_req_o` pulse.
- R4: A pass issues one erase-sector command (`fl_op_o` = 1, sector-aligned address) when at least one byte in its window is not 0xFF, and no erase otherwise.
- R5: Bytes of a touched sector that lie outside the request window keep their previous contents.
- R6: After completion, every byte in the request window holds the supplied write byte, taken in stream order.
- R7: Each pass writes back with SECTOR_BYTES/PAGE_BYTES program-page commands (`fl_op_o` = 2). Each command has a page-aligned address and is followed by exactly PAGE_BYTES cycles of `fl_wvalid_o`.
- R8: `req_ready_o` is 1 only while idle. A request offered while busy is ignored.
- R9: `done_o` is a one-cycle pulse, issued once per request, after the final program command has completed.
- R10: A zero-length request produces `done_o` and issues no flash command.
- R11: A request that runs past the top of the address space is truncated to end at the last byte of the device, and only the truncated number of data bytes is taken.
- R12: `wd_ready_o` is 1 only during the merge step of a pass, and exactly as many bytes as the pass length are taken there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle and accepting a request |
| req_addr_i | input | ADDR_W | Start byte address |
| req_len_i | input | ADDR_W+1 | Byte count |
| wd_valid_i | input | 1 | Write byte offered |
| wd_ready_o | output | 1 | Write byte accepted this cycle |
| wd_data_i | input | 8 | Write byte |
| done_o | output | 1 | Request finished pulse |
| fl_req_o | output | 1 | Flash command pulse |
| fl_op_o | output | 2 | 0 read byte, 1 erase sector, 2 program page |
| fl_addr_o | output | ADDR_W | Flash byte address of the command |
| fl_wvalid_o | output | 1 | Program data byte valid |
| fl_wdata_o | output | 8 | Program data byte |
| fl_done_i | input | 1 | Flash command completion pulse |
| fl_rdata_i | input | 8 | Read byte, valid with fl_done_i |

## Verification
The assertions assume that the flash raises exactly one `fl_done_i` pulse per command. That pulse never arrives in the cycle of the command. For a program command it comes only after the page of bytes has been streamed. The bench's flash model samples commands on the falling edge and answers one cycle later, so it stays within those assumptions. The model programs by AND-ing the stored byte with the new byte and erases by filling the sector with 0xFF, so a missing erase or a clobbered neighbour byte appears as a content mismatch. Host bytes are offered only when `wd_ready_o` is seen high, and a stray request is offered only while the block is busy.

// File: rtl/flw_pkg.sv
package flw_pkg;
  typedef enum logic [1:0] {
    FL_READ  = 2'd0,
    FL_ERASE = 2'd1,
    FL_PROG  = 2'd2
  } fl_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_ER_REQ, S_ER_WAIT,
    S_MERGE, S_PG_REQ, S_PG_DATA, S_PG_WAIT
  } flw_state_e;
endpackage

// File: rtl/flw_split.sv
// Pass geometry: sector base, in-sector offset, clipped pass length.
module flw_split #(
  parameter int ADDR_W       = 24,
  parameter int SECTOR_BYTES = 4096,
  localparam int SEC_W       = $clog2(SECTOR_BYTES),
  localparam int LEN_W       = ADDR_W + 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  rem_i,
  output logic [ADDR_W-1:0] sec_base_o,
  output logic [SEC_W-1:0]  off_o,
  output logic [LEN_W-1:0]  plen_o
);
  logic [LEN_W-1:0] room;

  assign off_o      = addr_i[SEC_W-1:0];
  assign sec_base_o = {addr_i[ADDR_W-1:SEC_W], {SEC_W{1'b0}}};
  assign room       = LEN_W'(SECTOR_BYTES) - LEN_W'(off_o);
  assign plen_o     = (rem_i <= room) ? rem_i : room;
endmodule

// File: rtl/flw_stage_buf.sv
// Sector staging buffer: one write port, combinational read.
module flw_stage_buf #(
  parameter int DEPTH = 4096,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/flash_rmw_writer.sv
module flash_rmw_writer #(
  parameter int ADDR_W       = 24,
  parameter int SECTOR_BYTES = 4096,
  parameter int PAGE_BYTES   = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [ADDR_W:0]   req_len_i,
  input  logic              wd_valid_i,
  output logic              wd_ready_o,
  input  logic [7:0]        wd_data_i,
  output logic              done_o,
  output logic              fl_req_o,
  output logic [1:0]        fl_op_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic              fl_wvalid_o,
  output logic [7:0]        fl_wdata_o,
  input  logic              fl_done_i,
  input  logic [7:0]        fl_rdata_i
);
  import flw_pkg::*;

  localparam int SEC_W = $clog2(SECTOR_BYTES);
  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int LEN_W = ADDR_W + 1;
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SECTOR_BYTES - 1);

  flw_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [SEC_W-1:0]  idx_q;
  logic              need_erase_q, last_pg_q, done_q;

  logic [ADDR_W-1:0] sec_base;
  logic [SEC_W-1:0]  off;
  logic [LEN_W-1:0]  plen;
  logic [SEC_W:0]    win_hi;
  logic              in_win, merge_last, rd_dirty, need_erase_d;
  logic [LEN_W-1:0]  room_dev, eff_len, rem_next;
  logic              buf_we;
  logic [7:0]        buf_wdata, buf_rdata;

  flw_split #(.ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES)) u_split (
    .addr_i    (addr_q),
    .rem_i     (rem_q),
    .sec_base_o(sec_base),
    .off_o     (off),
    .plen_o    (plen)
  );

  flw_stage_buf #(.DEPTH(SECTOR_BYTES)) u_buf (
    .clk_i  (clk_i),
    .we_i   (buf_we),
    .waddr_i(idx_q),
    .wdata_i(buf_wdata),
    .raddr_i(idx_q),
    .rdata_o(buf_rdata)
  );

  // Window of target bytes inside the current sector
  assign win_hi       = {1'b0, off} + plen[SEC_W:0];
  assign in_win       = ({1'b0, idx_q} >= {1'b0, off}) && ({1'b0, idx_q} < win_hi);
  assign merge_last   = ({1'b0, idx_q} + 1'b1) == win_hi;
  assign rd_dirty     = in_win && (fl_rdata_i != 8'hFF);
  assign need_erase_d = need_erase_q | rd_dirty;

  // Truncate at the top of the device
  assign room_dev = {1'b1, {ADDR_W{1'b0}}} - {1'b0, req_addr_i};
  assign eff_len  = (req_len_i < room_dev) ? req_len_i : room_dev;
  assign rem_next = rem_q - plen;

  assign buf_we    = (state_q == S_RD_WAIT && fl_done_i) || (state_q == S_MERGE && wd_valid_i);
  assign buf_wdata = (state_q == S_MERGE) ? wd_data_i : fl_rdata_i;

  assign req_ready_o = (state_q == S_IDLE);
  assign wd_ready_o  = (state_q == S_MERGE);
  assign done_o      = done_q;
  assign fl_wvalid_o = (state_q == S_PG_DATA);
  assign fl_wdata_o  = buf_rdata;

  always_comb begin
    fl_req_o  = 1'b0;
    fl_op_o   = FL_READ;
    fl_addr_o = sec_base + ADDR_W'(idx_q);
    unique case (state_q)
      S_RD_REQ: fl_req_o = 1'b1;
      S_ER_REQ: begin
        fl_req_o  = 1'b1;
        fl_op_o   = FL_ERASE;
        fl_addr_o = sec_base;
      end
      S_PG_REQ: begin
        fl_req_o = 1'b1;
        fl_op_o  = FL_PROG;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      addr_q       <= '0;
      rem_q        <= '0;
      idx_q        <= '0;
      need_erase_q <= 1'b0;
      last_pg_q    <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          if (eff_len == '0) begin
            done_q <= 1'b1;
          end else begin
            addr_q       <= req_addr_i;
            rem_q        <= eff_len;
            idx_q        <= '0;
            need_erase_q <= 1'b0;
            state_q      <= S_RD_REQ;
          end
        end
        S_RD_REQ: state_q <= S_RD_WAIT;
        S_RD_WAIT: if (fl_done_i) begin
          need_erase_q <= need_erase_d;
          if (idx_q == SEC_LAST) begin
            idx_q   <= off;
            state_q <= need_erase_d ? S_ER_REQ : S_MERGE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_RD_REQ;
          end
        end
        S_ER_REQ: state_q <= S_ER_WAIT;
        S_ER_WAIT: if (fl_done_i) state_q <= S_MERGE;
        S_MERGE: if (wd_valid_i) begin
          if (merge_last) begin
            idx_q   <= '0;
            state_q <= S_PG_REQ;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_PG_REQ: begin
          last_pg_q <= 1'b0;
          state_q   <= S_PG_DATA;
        end
        S_PG_DATA: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q[PG_W-1:0] == {PG_W{1'b1}}) begin
            last_pg_q <= (idx_q == SEC_LAST);
            state_q   <= S_PG_WAIT;
          end
        end
        S_PG_WAIT: if (fl_done_i) begin
          if (!last_pg_q) begin
            state_q <= S_PG_REQ;
          end else begin
            addr_q <= addr_q + ADDR_W'(plen);
            rem_q  <= rem_next;
            if (rem_next == '0) begin
              done_q  <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              idx_q        <= '0;
              need_erase_q <= 1'b0;
              state_q      <= S_RD_REQ;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_rmw_writer_chk.sv
module flash_rmw_writer_chk #(
  parameter int SECTOR_BYTES = 4096,
  parameter int PAGE_BYTES   = 256,
  localparam int SEC_W       = $clog2(SECTOR_BYTES),
  localparam int PG_W        = $clog2(PAGE_BYTES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             done_o,
  input logic             wd_ready_o,
  input logic             fl_req_o,
  input logic [1:0]       fl_op_o,
  input logic [SEC_W-1:0] addr_lo_i,
  input logic             fl_wvalid_o
);
  import flw_pkg::*;

  a_r8_cmd_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_req_o |-> !req_ready_o);

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);

  a_r3_cmd_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_req_o |=> !fl_req_o);

  a_r7_prog_page_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && fl_op_o == FL_PROG) |-> (addr_lo_i[PG_W-1:0] == '0));

  a_r4_erase_sector_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && fl_op_o == FL_ERASE) |-> (addr_lo_i == '0));

  a_r7_data_after_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_wvalid_o) |-> $past(fl_req_o && fl_op_o == FL_PROG));

  a_r12_merge_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_ready_o |-> (!fl_req_o && !fl_wvalid_o && !req_ready_o));
endmodule

bind flash_rmw_writer flash_rmw_writer_chk #(
  .SECTOR_BYTES(SECTOR_BYTES),
  .PAGE_BYTES  (PAGE_BYTES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .done_o     (done_o),
  .wd_ready_o (wd_ready_o),
  .fl_req_o   (fl_req_o),
  .fl_op_o    (fl_op_o),
  .addr_lo_i  (fl_addr_o[$clog2(SECTOR_BYTES)-1:0]),
  .fl_wvalid_o(fl_wvalid_o)
);

// File: tb/flash_rmw_writer_tb.sv
`timescale 1ns/1ps
module flash_rmw_writer_tb;
  localparam int AW  = 11;
  localparam int SB  = 256;
  localparam int PB  = 32;
  localparam int DEV = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [AW:0]   req_len = '0;
  logic          wd_valid = 1'b0, wd_ready;
  logic [7:0]    wd_data = '0;
  logic          done;
  logic          fl_req, fl_wvalid;
  logic [1:0]    fl_op;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_wdata;
  logic          fl_done = 1'b0;
  logic [7:0]    fl_rdata = '0;

  flash_rmw_writer #(.ADDR_W(AW), .SECTOR_BYTES(SB), .PAGE_BYTES(PB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len),
    .wd_valid_i(wd_valid), .wd_ready_o(wd_ready), .wd_data_i(wd_data),
    .done_o(done),
    .fl_req_o(fl_req), .fl_op_o(fl_op), .fl_addr_o(fl_addr),
    .fl_wvalid_o(fl_wvalid), .fl_wdata_o(fl_wdata),
    .fl_done_i(fl_done), .fl_rdata_i(fl_rdata)
  );

  int checks = 0, fails = 0;
  int n_read = 0, n_erase = 0, n_prog = 0, n_pbad = 0, done_cnt = 0;
  logic [7:0] fmem [DEV];
  logic [7:0] refm [DEV];
  logic [7:0] wd   [DEV];
  bit pend = 0;
  logic [7:0] pdata = '0;
  int pbase = 0, pcnt = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Flash model: program ANDs, erase fills 0xFF, done one cycle after the command
  initial begin
    forever begin
      @(negedge clk);
      fl_done = 1'b0;
      if (pend) begin
        fl_done  = 1'b1;
        fl_rdata = pdata;
        pend     = 0;
      end
      if (fl_req) begin
        case (fl_op)
          2'd0: begin n_read++; pdata = fmem[int'(fl_addr)]; pend = 1; end
          2'd1: begin
            n_erase++;
            for (int j = 0; j < SB; j++) fmem[(int'(fl_addr) / SB) * SB + j] = 8'hFF;
            pend = 1;
          end
          default: begin
            n_prog++;
            pbase = int'(fl_addr);
            pcnt  = 0;
            if (pbase % PB != 0) n_pbad++;
          end
        endcase
      end
      if (fl_wvalid) begin
        if (pcnt >= PB) n_pbad++;
        else fmem[pbase + pcnt] = fmem[pbase + pcnt] & fl_wdata;
        pcnt++;
        if (pcnt == PB) pend = 1;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) done_cnt++;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end

  task automatic do_write(int addr, int len, string tag);
    int eff, a, r, off, pl, dirty, passes, erases, r0, e0, p0, b0, d0, mism;
    eff = (len < DEV - addr) ? len : DEV - addr;
    for (int i = 0; i < eff; i++) wd[i] = 8'($urandom);
    passes = 0; erases = 0; a = addr; r = eff;
    while (r > 0) begin
      off = a % SB;
      pl  = (r <= SB - off) ? r : SB - off;
      dirty = 0;
      for (int j = 0; j < pl; j++) if (refm[a + j] != 8'hFF) dirty = 1;
      erases += dirty; passes++; a += pl; r -= pl;
    end
    r0 = n_read; e0 = n_erase; p0 = n_prog; b0 = n_pbad; d0 = done_cnt;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(addr); req_len = (AW+1)'(len);
    @(negedge clk);
    req_valid = 1'b0;
    if (eff > 0) begin
      chk(!req_ready, "R8", {tag, " ready while busy"}, int'(req_ready), 0);
      chk(!wd_ready, "R12", {tag, " data ready during read"}, int'(wd_ready), 0);
      // stray request while busy must be ignored (R8)
      req_valid = 1'b1; req_addr = ~AW'(addr); req_len = 12'd7;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < eff; i++) begin
        while (!wd_ready) @(negedge clk);
        wd_valid = 1'b1; wd_data = wd[i];
        @(negedge clk);
        wd_valid = 1'b0;
      end
      while (done_cnt == d0) @(negedge clk);
      chk(n_prog - p0 == passes * (SB / PB), "R9", {tag, " programs before done"},
          n_prog - p0, passes * (SB / PB));
    end
    repeat (4) @(negedge clk);
    for (int i = 0; i < eff; i++) refm[addr + i] = wd[i];
    mism = 0;
    for (int i = 0; i < DEV; i++) if (fmem[i] !== refm[i]) mism++;
    chk(done_cnt - d0 == 1, (eff == 0) ? "R10" : "R9", {tag, " done pulses"}, done_cnt - d0, 1);
    chk(n_read - r0 == passes * SB, "R3", {tag, " sector reads"}, n_read - r0, passes * SB);
    chk(n_erase - e0 == erases, "R4", {tag, " erases"}, n_erase - e0, erases);
    chk(n_prog - p0 == passes * (SB / PB), "R7", {tag, " page programs"}, n_prog - p0, passes * (SB / PB));
    chk(n_pbad == b0, "R7", {tag, " page alignment/length"}, n_pbad - b0, 0);
    chk(mism == 0, "R5", {tag, " content mismatches (R2 R6)"}, mism, 0);
    chk(!wd_ready && req_ready, "R12", {tag, " idle after request"}, int'(wd_ready), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEV; i++) begin
      fmem[i] = (i < 3 * SB) ? 8'hFF : 8'($urandom);
      refm[i] = fmem[i];
    end
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !fl_req && !wd_ready && !fl_wvalid, "R1", "reset outputs",
        {req_ready, done, fl_req, wd_ready, fl_wvalid}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !fl_req, "R1", "idle after reset", int'(req_ready), 1);

    do_write(10, 20, "erased_no_erase_R4");
    do_write(12, 8, "overwrite_R5");
    do_write(250, 300, "cross_sector_R2");
    do_write(40, 0, "zero_len_R10");
    do_write(2000, 200, "truncate_R11");
    do_write(512, 256, "full_sector_R6");
    do_write(1024, 1, "single_byte_R6");
    for (int t = 0; t < 6; t++) begin
      do_write(int'($urandom_range(DEV - 1, 0)), int'($urandom_range(300, 0)), "random");
    end
    summary();
    $finish;
  end
endmodule